// File: doc/BRIEF.md
# Hamming SECDED (8,4) Codec

This block protects a 4-bit data nibble with an 8-bit Hamming codeword that can correct any single bit flip and detect any double flip. The encode side takes a nibble and returns its codeword; the decode side, independent of it, takes a stored and possibly damaged codeword and returns the repaired nibble together with two status flags. Both sides are combinational cores; a parameter selects whether their outputs pass through one register stage.

Check bits sit at the power-of-two positions of the codeword, so the recomputed syndrome is itself the index of a flipped position. An eighth overall parity bit tells a lone flip (parity broken) from a pair of flips (parity intact). A broken parity with a zero syndrome means only the parity bit was hit.

Top module: `secded84_codec`

## Requirements
- R1: Codeword position p (1 to 8) is carried on word bit p-1. Positions 1, 2, 4 hold check bits, position 8 holds the overall parity bit, and nibble bits 0, 1, 2, 3 sit at positions 3, 5, 6, 7.
- R2: The check bit at position 2^k is the XOR of the data positions whose index has bit k set, and position 8 makes the count of ones in the whole word even; nibble 4'b0101 encodes to 8'h2D.
- R3: A word with zero syndrome and even parity decodes to its own data bits with both flags low.
- R4: A single flip at any of positions 1 to 7 yields the original nibble with the single-fix flag high and the double-error flag low; flipping position 3 of 8'h2D (giving 8'h29) yields nibble 4'b0101.
- R5: A flip of position 8 alone returns the data bits unchanged and raises the single-fix flag.
- R6: Any two flipped positions raise the double-error flag, keep the single-fix flag low, and return the received data bits without alteration; 8'h39 is one such word.
- R7: The single-fix and double-error flags are never high together.
- R8: With REG_OUT = 1 every output follows its inputs one clock later, and an active-low reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rstN | input | 1 | Asynchronous active-low reset |
| encData | input | 4 | Nibble to encode |
| encWord | output | 8 | Codeword for encData |
| decWord | input | 8 | Received codeword |
| decData | output | 4 | Repaired nibble |
| singleFix | output | 1 | A single flip was found and repaired |
| doubleErr | output | 1 | Two flips found, data not repaired |

## Verification
All sixteen nibbles are encoded and compared with codewords built in the bench from the coverage rule, which separates wrong check coverage from wrong bit placement. Each codeword is then decoded clean, with each of its eight positions flipped, and with each of the 28 flip pairs: clean words show that nothing is altered, single flips tell data-position repair apart from check-bit and parity-bit hits, and pairs show that repair is suppressed and the right flag chosen. The worked example words are applied on their own, and reset and the one-cycle delay are checked directly.

// File: rtl/secded84_pkg.sv
package secded84_pkg;
  localparam int DATA_W = 4;
  localparam int SYN_W  = 3;
  localparam int CODE_W = (1 << SYN_W);

  // Strobes from the classifier to the datapath.
  typedef struct packed {
    logic fixData;    // flip the position named by the syndrome
    logic fixParity;  // only the parity bit was hit
    logic dblErr;     // two flips, leave data untouched
  } decStrobe_t;

  // Codeword position (1-based) of nibble bit i: skip powers of two.
  function automatic int dataPos(input int i);
    int cnt;
    dataPos = 0;
    cnt = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == i) dataPos = p;
        cnt++;
      end
    end
  endfunction
endpackage

// File: rtl/secded84_datapath.sv
module secded84_datapath
  import secded84_pkg::*;
(
  input  logic [DATA_W-1:0] encData,
  output logic [CODE_W-1:0] encWord,
  input  logic [CODE_W-1:0] decWord,
  output logic [SYN_W-1:0]  syndrome,
  output logic              parityFail,
  input  decStrobe_t        strobe,
  output logic [DATA_W-1:0] decData
);
  logic [CODE_W-1:0] fixedWord;

  // Encoder: place data, then fill check bits and overall parity.
  always_comb begin
    logic c;
    encWord = '0;
    for (int i = 0; i < DATA_W; i++) encWord[dataPos(i)-1] = encData[i];
    for (int k = 0; k < SYN_W; k++) begin
      c = 1'b0;
      for (int p = 1; p < CODE_W; p++)
        if (((p >> k) & 1) == 1) c = c ^ encWord[p-1];
      encWord[(1 << k) - 1] = c;
    end
    encWord[CODE_W-1] = ^encWord[CODE_W-2:0];
  end

  // Syndrome: XOR over each coverage group including the stored check bit.
  always_comb begin
    for (int k = 0; k < SYN_W; k++) begin
      syndrome[k] = 1'b0;
      for (int p = 1; p < CODE_W; p++)
        if (((p >> k) & 1) == 1) syndrome[k] = syndrome[k] ^ decWord[p-1];
    end
  end

  assign parityFail = ^decWord;

  always_comb begin
    fixedWord = decWord;
    if (strobe.fixData) fixedWord[syndrome - 1'b1] = ~decWord[syndrome - 1'b1];
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) decData[i] = fixedWord[dataPos(i)-1];
  end

  // R2: every produced codeword has even weight
  always_comb assert_enc_even_R2: assert (^encWord == 1'b0);
  // R6: on a double error the datapath must not modify the word
  always_comb if (strobe.dblErr) assert_dbl_nofix_R6: assert (fixedWord == decWord);
endmodule

// File: rtl/secded84_ctrl.sv
module secded84_ctrl
  import secded84_pkg::*;
(
  input  logic [SYN_W-1:0] syndrome,
  input  logic             parityFail,
  output decStrobe_t       strobe
);
  logic synHit;
  assign synHit = (syndrome != '0);

  always_comb begin
    strobe.fixData   = synHit && parityFail;
    strobe.fixParity = !synHit && parityFail;
    strobe.dblErr    = synHit && !parityFail;
  end

  // R7: exactly one class at most
  always_comb assert_one_class_R7:
    assert ($onehot0({strobe.fixData, strobe.fixParity, strobe.dblErr}));
endmodule

// File: rtl/secded84_codec.sv
module secded84_codec
  import secded84_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        encData,
  output logic [7:0]        encWord,
  input  logic [7:0]        decWord,
  output logic [3:0]        decData,
  output logic              singleFix,
  output logic              doubleErr
);
  logic [CODE_W-1:0] encWordC;
  logic [DATA_W-1:0] decDataC;
  logic [SYN_W-1:0]  syndrome;
  logic              parityFail;
  decStrobe_t        strobe;

  secded84_datapath u_dp (
    .encData(encData), .encWord(encWordC), .decWord(decWord),
    .syndrome(syndrome), .parityFail(parityFail), .strobe(strobe),
    .decData(decDataC)
  );

  secded84_ctrl u_ctrl (
    .syndrome(syndrome), .parityFail(parityFail), .strobe(strobe)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          encWord   <= '0;
          decData   <= '0;
          singleFix <= 1'b0;
          doubleErr <= 1'b0;
        end else begin
          encWord   <= encWordC;
          decData   <= decDataC;
          singleFix <= strobe.fixData | strobe.fixParity;
          doubleErr <= strobe.dblErr;
        end
      end

      assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
        !(singleFix && doubleErr));
      assert_clean_pass_R3: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && !singleFix && !doubleErr) |->
          decData == {$past(decWord[6]), $past(decWord[5]), $past(decWord[4]), $past(decWord[2])});
      assert_dbl_raw_R6: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && doubleErr) |->
          decData == {$past(decWord[6]), $past(decWord[5]), $past(decWord[4]), $past(decWord[2])});
      assert_enc_even_R8: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) |-> (^encWord == 1'b0));
    end else begin : g_comb
      assign encWord   = encWordC;
      assign decData   = decDataC;
      assign singleFix = strobe.fixData | strobe.fixParity;
      assign doubleErr = strobe.dblErr;
    end
  endgenerate
endmodule

// File: tb/secded84_codec_bench.sv
module secded84_codec_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] encData = '0;
  logic [7:0] decWord = '0;
  logic [7:0] encWord;
  logic [3:0] decData;
  logic singleFix, doubleErr;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  secded84_codec u_secded84_codec (
    .clk(clk), .rstN(rstN), .encData(encData), .encWord(encWord),
    .decWord(decWord), .decData(decData), .singleFix(singleFix), .doubleErr(doubleErr)
  );

  // Reference encoder from the coverage rule (R1, R2).
  function automatic logic [7:0] refEnc(input logic [3:0] d);
    logic [7:0] w;
    int pos[4];
    pos = '{3, 5, 6, 7};
    w = '0;
    for (int i = 0; i < 4; i++) w[pos[i]-1] = d[i];
    for (int k = 0; k < 3; k++) begin
      logic c;
      c = 0;
      for (int p = 3; p <= 7; p++)
        if (((p >> k) & 1) == 1 && (p & (p - 1)) != 0) c ^= w[p-1];
      w[(1 << k) - 1] = c;
    end
    w[7] = ^w[6:0];
    return w;
  endfunction

  function automatic logic [3:0] rawData(input logic [7:0] w);
    return {w[6], w[5], w[4], w[2]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic applyDec(input logic [7:0] w, input logic [3:0] expD,
                          input logic expS, input logic expX, input string req);
    @(negedge clk);
    decWord = w;
    @(posedge clk);
    @(negedge clk);
    check(req, {10'd0, expS, expX, expD}, {10'd0, singleFix, doubleErr, decData});
  endtask

  initial begin
    // R8: reset state
    decWord = 8'hFF;
    encData = 4'hF;
    repeat (3) @(negedge clk);
    check("R8 reset", {4'd0, encWord, decData}, 16'd0);
    check("R8 reset flags", {14'd0, singleFix, doubleErr}, 16'd0);
    rstN = 1'b1;

    // R2 worked example, R8 one-cycle delay
    @(negedge clk);
    encData = 4'b0101;
    #1 check("R8 delay", {8'd0, encWord}, {8'd0, refEnc(4'hF)});
    @(posedge clk);
    @(negedge clk);
    check("R2 example", {8'd0, encWord}, 16'h002D);

    // R1 R2: all nibbles
    for (int d = 0; d < 16; d++) begin
      @(negedge clk);
      encData = d[3:0];
      @(posedge clk);
      @(negedge clk);
      check("R1 R2 encode", {8'd0, encWord}, {8'd0, refEnc(d[3:0])});
    end

    applyDec(8'h29, 4'b0101, 1'b1, 1'b0, "R4 example");
    applyDec(8'h39, rawData(8'h39), 1'b0, 1'b1, "R6 example");

    for (int d = 0; d < 16; d++) begin
      logic [7:0] cw;
      cw = refEnc(d[3:0]);
      applyDec(cw, d[3:0], 1'b0, 1'b0, "R3 clean");
      for (int a = 0; a < 7; a++)
        applyDec(cw ^ (8'd1 << a), d[3:0], 1'b1, 1'b0, "R4 single");
      applyDec(cw ^ 8'h80, d[3:0], 1'b1, 1'b0, "R5 parity bit");
      for (int a = 0; a < 8; a++)
        for (int b = a + 1; b < 8; b++) begin
          logic [7:0] bad;
          bad = cw ^ (8'd1 << a) ^ (8'd1 << b);
          applyDec(bad, rawData(bad), 1'b0, 1'b1, "R6 R7 double");
        end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule